// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or discarded. It looks at the first sixteen header bytes (destination address, source address, type and, when present, the VLAN tag control word), a tag-present flag and a set of receive-control bits. It checks the frame against three tables: sixteen exact-address entries, a 4096-bit multicast hash table and a 4096-bit VLAN membership table. The verdict is registered and comes out one cycle after the header strobe. With it come two strobes that tell a statistics block whether the frame was taken as broadcast or as multicast.

The three tables are loaded through a single-word write port. A two-bit selector picks the table and an index picks the 32-bit word. The rules are tried in a fixed order. VLAN rejection comes first. Then unicast promiscuous, multicast promiscuous, broadcast accept, exact match and hash match follow. The first rule that fires decides the frame. A frame that no rule accepts is dropped.

Top module: `rxf_top`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after a cycle with `hdr_valid` high. `dec_accept`, `bc_hit` and `mc_hit` are low whenever `dec_valid` is low.
- R2: When `tag_present` and `vlan_filter_en` are both set, the VLAN ID is the low 12 bits of {byte14, byte15}. Bits [11:5] of the ID pick the VLAN table word and bits [4:0] pick the bit within it. A clear bit drops the frame and overrides every later rule. When either input is low, the VLAN table is not consulted.
- R3: With `uc_promisc` set, a frame whose destination is unicast (bit 0 of byte 0 clear) is accepted with no hit strobe. A multicast or broadcast frame is not accepted by this rule.
- R4: With `mc_promisc` set, any frame whose byte 0 bit 0 is set is accepted, and `mc_hit` is raised.
- R5: With `bc_accept` set, a destination of all-ones is accepted and `bc_hit` is raised. With `bc_accept` clear, that rule does not accept.
- R6: Entry e of the exact table (e = 0..15) is table word 2e (low) and word 2e+1 (high). The low word holds bytes 0..3 with byte 0 in bits [7:0]. The high word holds bytes 4..5 in bits [15:0], and bit 31 is the valid flag. A valid entry equal to the destination accepts the frame with no hit strobe. An entry whose valid flag is clear never matches.
- R7: The hash index is the 16-bit value {byte5, byte4} shifted right by 4, 3, 2 or 0 for `mc_offset` 0, 1, 2 or 3, keeping the low 12 bits.
- R8: Hash index bits [11:5] pick the hash table word and bits [4:0] pick the bit. A set bit accepts the frame and raises `mc_hit`.
- R9: A frame that no rule accepts is dropped: `dec_accept` is 0 and both strobes are 0.
- R10: On a cycle with `wr_en` high, `wr_data` is stored into a word chosen by `wr_sel` and `wr_idx`: 0 selects the exact table, 1 the hash table, 2 the VLAN table. Selector 3 writes nothing. An exact-table write with `wr_idx` of 32 or more writes nothing.
- R11: Reset clears every table word and all outputs.
- R12: Precedence is VLAN rejection, unicast promiscuous, multicast promiscuous, broadcast, exact, hash. A broadcast frame taken by the multicast promiscuous rule raises `mc_hit`, not `bc_hit`. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header bytes valid this cycle |
| hdr_bytes | input | 128 | Header bytes 0..15, byte i in bits [8i+7:8i] |
| tag_present | input | 1 | Frame carries a VLAN tag |
| uc_promisc | input | 1 | Accept all unicast frames |
| mc_promisc | input | 1 | Accept all multicast frames |
| bc_accept | input | 1 | Accept broadcast frames |
| vlan_filter_en | input | 1 | Apply VLAN membership table |
| mc_offset | input | 2 | Hash shift select |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: 0 exact, 1 hash, 2 VLAN, 3 none |
| wr_idx | input | 7 | Word index within the selected table |
| wr_data | input | 32 | Word to store |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame kept |
| bc_hit | output | 1 | Accepted as broadcast |
| mc_hit | output | 1 | Accepted as multicast |

## Verification
Every verdict and both strobes are due exactly one clock edge after the edge that samples `hdr_valid`. Inputs change on the falling edge, and the bench samples the outputs on the following falling edge. One cycle later it checks again that `dec_valid` and the strobes have dropped. A table write takes effect on the edge that samples it, so a header sent on the next falling edge already sees the new word. Each directed case programs the tables first and then checks the verdict at that fixed point.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int WORD_W        = 32;
    localparam int TBL_WORDS     = 128;
    localparam int LOOKUP_W      = 12;
    localparam int HDR_BYTES     = 16;
    localparam int EXACT_ENTRIES = 16;

    typedef enum logic [1:0] {
        SEL_EXACT = 2'd0,
        SEL_HASH  = 2'd1,
        SEL_VLAN  = 2'd2,
        SEL_NONE  = 2'd3
    } tbl_sel_e;

    typedef struct packed {
        logic valid;
        logic accept;
        logic bc_hit;
        logic mc_hit;
    } verdict_t;

    // Group-address hash: {byte5, byte4} shifted by an amount picked by the offset code
    function automatic logic [LOOKUP_W-1:0] hash_index(input logic [7:0] b4,
                                                       input logic [7:0] b5,
                                                       input logic [1:0] off);
        logic [15:0] v;
        v = {b5, b4};
        case (off)
            2'd0:    return v[LOOKUP_W+3:4];
            2'd1:    return v[LOOKUP_W+2:3];
            2'd2:    return v[LOOKUP_W+1:2];
            default: return v[LOOKUP_W-1:0];
        endcase
    endfunction
endpackage

// File: rtl/rxf_table_store.sv
module rxf_table_store #(
    parameter int WORDS = 128,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_idx,
    input  logic [W-1:0]              wr_data,
    output logic [WORDS-1:0][W-1:0]   words
);
    typedef struct packed {
        logic [WORDS-1:0][W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.mem;

    // R10: a written word is readable on the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> words[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rxf_bit_lookup.sv
module rxf_bit_lookup #(
    parameter int WORDS = 128,
    parameter int W     = 32,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BSEL_W = $clog2(W),
    localparam int IDX_W  = WSEL_W + BSEL_W
) (
    input  logic [WORDS-1:0][W-1:0] words,
    input  logic [IDX_W-1:0]        idx,
    output logic                    hit
);
    logic [W-1:0] sel_word;

    always_comb begin
        sel_word = words[idx[IDX_W-1:BSEL_W]];
        hit      = sel_word[idx[BSEL_W-1:0]];
    end
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match #(
    parameter int ENTRIES = 16,
    parameter int W       = 32,
    localparam int NWORDS = 2 * ENTRIES
) (
    input  logic [NWORDS-1:0][W-1:0] words,
    input  logic [47:0]              dest,
    output logic                     hit
);
    logic [ENTRIES-1:0] entry_hit;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [W-1:0] lo_w, hi_w;
        assign lo_w = words[2*e];
        assign hi_w = words[2*e+1];
        assign entry_hit[e] = hi_w[W-1] &&
                              (lo_w == dest[31:0]) &&
                              (hi_w[15:0] == dest[47:32]);
    end

    assign hit = |entry_hit;
endmodule

// File: rtl/rxf_top.sv
module rxf_top
    import rxf_pkg::*;
#(
    parameter int ENTRIES = EXACT_ENTRIES,
    parameter int WORDS   = TBL_WORDS,
    parameter int W       = WORD_W,
    localparam int EX_WORDS = 2 * ENTRIES,
    localparam int EX_AW    = $clog2(EX_WORDS),
    localparam int AW       = $clog2(WORDS),
    localparam int HDR_W    = HDR_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [HDR_W-1:0] hdr_bytes,
    input  logic             tag_present,
    input  logic             uc_promisc,
    input  logic             mc_promisc,
    input  logic             bc_accept,
    input  logic             vlan_filter_en,
    input  logic [1:0]       mc_offset,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [AW-1:0]    wr_idx,
    input  logic [W-1:0]     wr_data,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             bc_hit,
    output logic             mc_hit
);
    logic [EX_WORDS-1:0][W-1:0] ex_words;
    logic [WORDS-1:0][W-1:0]    hash_words;
    logic [WORDS-1:0][W-1:0]    vlan_words;

    logic ex_we, hash_we, vlan_we;
    logic [47:0] dest;
    logic [LOOKUP_W-1:0] vid, hidx;
    logic is_bc, is_mc, exact_hit, hash_hit, vlan_hit, vlan_block;

    verdict_t v_d, v_q;

    // Table write decode; out-of-range exact indices are dropped
    always_comb begin
        ex_we   = wr_en && (tbl_sel_e'(wr_sel) == SEL_EXACT) && (32'(wr_idx) < EX_WORDS);
        hash_we = wr_en && (tbl_sel_e'(wr_sel) == SEL_HASH);
        vlan_we = wr_en && (tbl_sel_e'(wr_sel) == SEL_VLAN);
    end

    rxf_table_store #(.WORDS(EX_WORDS), .W(W)) u_exact_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(ex_we),
        .wr_idx(wr_idx[EX_AW-1:0]), .wr_data(wr_data), .words(ex_words));

    rxf_table_store #(.WORDS(WORDS), .W(W)) u_hash_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(hash_we),
        .wr_idx(wr_idx), .wr_data(wr_data), .words(hash_words));

    rxf_table_store #(.WORDS(WORDS), .W(W)) u_vlan_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(vlan_we),
        .wr_idx(wr_idx), .wr_data(wr_data), .words(vlan_words));

    // Header field extraction
    always_comb begin
        dest  = hdr_bytes[47:0];
        is_mc = hdr_bytes[0];
        is_bc = (dest == 48'hFFFF_FFFF_FFFF);
        vid   = {hdr_bytes[115:112], hdr_bytes[127:120]};
        hidx  = hash_index(hdr_bytes[39:32], hdr_bytes[47:40], mc_offset);
    end

    rxf_exact_match #(.ENTRIES(ENTRIES), .W(W)) u_exact (
        .words(ex_words), .dest(dest), .hit(exact_hit));

    rxf_bit_lookup #(.WORDS(WORDS), .W(W)) u_hash_lu (
        .words(hash_words), .idx(hidx), .hit(hash_hit));

    rxf_bit_lookup #(.WORDS(WORDS), .W(W)) u_vlan_lu (
        .words(vlan_words), .idx(vid), .hit(vlan_hit));

    assign vlan_block = tag_present && vlan_filter_en && !vlan_hit;

    // Fixed-priority verdict
    always_comb begin
        v_d       = '0;
        v_d.valid = hdr_valid;
        if (hdr_valid && !vlan_block) begin
            if (uc_promisc && !is_mc && !is_bc) begin
                v_d.accept = 1'b1;
            end else if (is_mc && mc_promisc) begin
                v_d.accept = 1'b1;
                v_d.mc_hit = 1'b1;
            end else if (is_bc && bc_accept) begin
                v_d.accept = 1'b1;
                v_d.bc_hit = 1'b1;
            end else if (exact_hit) begin
                v_d.accept = 1'b1;
            end else if (hash_hit) begin
                v_d.accept = 1'b1;
                v_d.mc_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign dec_valid  = v_q.valid;
    assign dec_accept = v_q.accept;
    assign bc_hit     = v_q.bc_hit;
    assign mc_hit     = v_q.mc_hit;

    // R1: verdict follows the header strobe by one cycle
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> dec_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !dec_valid && !dec_accept && !bc_hit && !mc_hit);
    // R2: a VLAN miss forbids acceptance
    p_vlan_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && tag_present && vlan_filter_en && !vlan_hit |=> !dec_accept);
    // R3: untagged unicast under unicast promiscuous is accepted silently
    p_uc_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && uc_promisc && !hdr_bytes[0] && !(tag_present && vlan_filter_en)
        |=> dec_accept && !bc_hit && !mc_hit);
    // R5: broadcast strobe only with acceptance
    p_bc_needs_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bc_hit |-> dec_accept);
    // R8: multicast strobe only with acceptance
    p_mc_needs_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mc_hit |-> dec_accept);
    // R12: strobes are mutually exclusive
    p_single_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bc_hit, mc_hit}) <= 1);
endmodule

// File: tb/rxf_top_tb_top.sv
`timescale 1ns/1ps
module rxf_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic [127:0] hdr_bytes = '0;
    logic         tag_present = 1'b0;
    logic         uc_promisc = 1'b0, mc_promisc = 1'b0, bc_accept = 1'b0, vlan_filter_en = 1'b0;
    logic [1:0]   mc_offset = 2'd0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [6:0]   wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic         dec_valid, dec_accept, bc_hit, mc_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxf_top dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_bytes(hdr_bytes),
        .tag_present(tag_present), .uc_promisc(uc_promisc), .mc_promisc(mc_promisc),
        .bc_accept(bc_accept), .vlan_filter_en(vlan_filter_en), .mc_offset(mc_offset),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .bc_hit(bc_hit), .mc_hit(mc_hit));

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual {valid,accept,bc,mc}=%b expected %b", req, what, act, exp);
        end
    endtask

    // Destination given with byte 0 as the most significant byte
    function automatic logic [127:0] mk_hdr(input logic [47:0] da, input logic [15:0] tci);
        logic [127:0] h;
        h = '0;
        for (int i = 0; i < 6; i++) h[8*i +: 8] = da[8*(5-i) +: 8];
        h[55:48]   = 8'h02;
        h[95:88]   = 8'h01;
        h[103:96]  = 8'h81;
        h[111:104] = 8'h00;
        h[119:112] = tci[15:8];
        h[127:120] = tci[7:0];
        return h;
    endfunction

    task automatic tbl_write(input logic [1:0] sel, input logic [6:0] idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ctl = {uc, mc, bc, vlan_en}; exp = {accept, bc, mc}
    task automatic send(input logic [47:0] da, input logic [15:0] tci, input logic tag,
                        input logic [3:0] ctl, input logic [1:0] off,
                        input logic [2:0] exp, input string req, input string what);
        @(negedge clk);
        hdr_bytes = mk_hdr(da, tci);
        tag_present = tag;
        {uc_promisc, mc_promisc, bc_accept, vlan_filter_en} = ctl;
        mc_offset = off;
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        chk({dec_valid, dec_accept, bc_hit, mc_hit}, {1'b1, exp}, req, what);
    endtask

    task automatic t_reset();
        chk({dec_valid, dec_accept, bc_hit, mc_hit}, 4'b0000, "R11", "outputs in reset");
        @(negedge clk); rst_n = 1'b1;
        send(48'h02AA_BBCC_DDEE, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R11", "tables clear after reset");
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R9", "unmatched multicast drops");
    endtask

    task automatic t_latency();
        send(48'h0211_2233_4455, 16'h0, 1'b0, 4'b1000, 2'd0, 3'b100, "R1", "verdict one cycle after strobe");
        @(negedge clk);
        chk({dec_valid, dec_accept, bc_hit, mc_hit}, 4'b0000, "R1", "verdict gone without strobe");
    endtask

    task automatic t_promisc();
        send(48'h0211_2233_4455, 16'h0, 1'b0, 4'b1000, 2'd0, 3'b100, "R3", "unicast promiscuous accepts unicast");
        send(48'h0100_5E00_0001, 16'h0, 1'b0, 4'b1000, 2'd0, 3'b000, "R3", "unicast promiscuous ignores multicast");
        send(48'hFFFF_FFFF_FFFF, 16'h0, 1'b0, 4'b1000, 2'd0, 3'b000, "R3", "unicast promiscuous ignores broadcast");
        send(48'h0100_5E00_0001, 16'h0, 1'b0, 4'b0100, 2'd0, 3'b101, "R4", "multicast promiscuous");
        send(48'h0211_2233_4455, 16'h0, 1'b0, 4'b0100, 2'd0, 3'b000, "R4", "multicast promiscuous ignores unicast");
    endtask

    task automatic t_broadcast();
        send(48'hFFFF_FFFF_FFFF, 16'h0, 1'b0, 4'b0010, 2'd0, 3'b110, "R5", "broadcast accepted");
        send(48'hFFFF_FFFF_FFFF, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R5", "broadcast without enable");
        send(48'hFFFF_FFFF_FFFF, 16'h0, 1'b0, 4'b0110, 2'd0, 3'b101, "R12", "multicast rule precedes broadcast");
    endtask

    task automatic t_exact();
        tbl_write(2'd0, 7'd6, 32'hCCBB_AA02);
        tbl_write(2'd0, 7'd7, 32'h8000_EEDD);
        send(48'h02AA_BBCC_DDEE, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b100, "R6", "exact entry 3 match");
        send(48'h02AA_BBCC_DDEF, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R6", "exact byte 5 differs");
        tbl_write(2'd0, 7'd30, 32'h0000_0002);
        tbl_write(2'd0, 7'd31, 32'h8000_0F00);
        send(48'h0200_0000_000F, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b100, "R6", "exact entry 15 match");
        tbl_write(2'd0, 7'd10, 32'h0302_0102);
        tbl_write(2'd0, 7'd11, 32'h0000_0504);
        send(48'h0201_0203_0405, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R6", "entry without valid flag");
    endtask

    task automatic t_write_port();
        tbl_write(2'd3, 7'd12, 32'h0909_0902);
        tbl_write(2'd3, 7'd13, 32'h8000_0909);
        send(48'h0209_0909_0909, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R10", "selector 3 stores nothing");
        tbl_write(2'd0, 7'd44, 32'h0707_0702);
        tbl_write(2'd0, 7'd45, 32'h8000_0707);
        send(48'h0207_0707_0707, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b000, "R10", "exact index above 31 stores nothing");
    endtask

    task automatic t_hash();
        // {byte5,byte4} = 0x1234: indices 0x123, 0x246, 0x48D, 0x234
        tbl_write(2'd1, 7'd9, 32'h0000_0008);
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd0, 3'b101, "R7", "hash offset 0 word 9 bit 3");
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd1, 3'b000, "R8", "hash offset 1 word clear");
        tbl_write(2'd1, 7'd18, 32'h0000_0040);
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd1, 3'b101, "R7", "hash offset 1 word 18 bit 6");
        tbl_write(2'd1, 7'd36, 32'h0000_2000);
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd2, 3'b101, "R7", "hash offset 2 word 36 bit 13");
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd3, 3'b000, "R8", "hash offset 3 word 17 clear");
        tbl_write(2'd1, 7'd36, 32'h0000_0000);
        tbl_write(2'd1, 7'd17, 32'h0010_0000);
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd3, 3'b101, "R7", "hash offset 3 word 17 bit 20");
        send(48'h0100_5E00_3412, 16'h0, 1'b0, 4'b0000, 2'd2, 3'b000, "R8", "hash word cleared again");
    endtask

    task automatic t_vlan();
        send(48'h0211_2233_4455, 16'h2065, 1'b1, 4'b1001, 2'd0, 3'b000, "R2", "VLAN 0x065 not member");
        tbl_write(2'd2, 7'd3, 32'h0000_0020);
        send(48'h0211_2233_4455, 16'h2065, 1'b1, 4'b1001, 2'd0, 3'b100, "R2", "VLAN 0x065 member");
        send(48'h0211_2233_4455, 16'h2064, 1'b1, 4'b1001, 2'd0, 3'b000, "R2", "VLAN 0x064 neighbour bit");
        send(48'h0211_2233_4455, 16'h00FF, 1'b0, 4'b1001, 2'd0, 3'b100, "R2", "untagged skips VLAN table");
        send(48'h0211_2233_4455, 16'h00FF, 1'b1, 4'b1000, 2'd0, 3'b100, "R2", "filter disabled skips VLAN table");
        send(48'hFFFF_FFFF_FFFF, 16'h00FF, 1'b1, 4'b0011, 2'd0, 3'b000, "R12", "VLAN rejection precedes broadcast");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_promisc();
        t_broadcast();
        t_exact();
        t_write_port();
        t_hash();
        t_vlan();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule